// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the clock-by-clock controller that carries out one granted DMA service. It asks for the system bus and waits for the grant. It then steps through the working states of every transfer. Along the way it drives the upper-address strobe, the address enable, the memory and I/O read and write strobes, and the end-of-process pulse. All outputs are active high; pin polarity is handled outside the block. The channel register file and the priority arbiter sit beside it. They provide the current address, a last-transfer flag, the selected channel's service mode, transfer type, timing and count direction, and a level that says a service is wanted.

Each state lasts one clock. They are idle, hold-wait, S1 (upper address byte out and strobed), S2, S3, a wait state, and S4, where the strobes complete and the register file is told to step. The upper byte state S1 runs on the first transfer of every service. After that it runs only when the next address carries or borrows across bit 7. Compressed timing drops S3 so that a transfer takes two clocks. Single, block and demand services each end or give up the bus by their own rule.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, hold_req, addr_en, addr_strobe, all four bus strobes, eop_out and xfer_step are low.
- R2: svc_req seen in idle raises hold_req one clock later. The block then waits with addr_en low for as long as hold_ack stays low. The clock after hold_ack is sampled high is S1, with addr_en and addr_strobe high and hi_addr_out equal to the upper byte of cur_addr.
- R3: Within one service, S1 (addr_strobe high) recurs only for a transfer whose address differs from the previous one above bit 7. The previous address is incremented when addr_down is 0 and decremented when it is 1.
- R4: Without wait states, a transfer occupies S2, S3 and S4 in normal timing, or S2 and S4 when compressed is 1, plus one clock for S1 when it runs.
- R5: A move transfer with ready low enters a wait state. The check is made at S3 in normal timing and at S2 in compressed timing. The block stays in the wait state until a clock where ready is high, then goes to S4.
- R6: xfer_type 01 (write) drives io_rd and mem_wr, and 10 (read) drives mem_rd and io_wr. The read-side strobe is high in S3, wait states and S4. The write-side strobe is high in wait states and S4.
- R7: xfer_type 00 or 11 (verify) keeps all four bus strobes low and ignores ready. Addresses, S1 and eop_out behave as for a move.
- R8: svc_mode 01 (single) makes exactly one transfer and then returns to idle with hold_req low.
- R9: svc_mode 10 or 11 (block) continues transfer after transfer until tc_last is high in S4 or an external end of process is seen.
- R10: svc_mode 00 (demand) also ends at S4 of any transfer during which dreq_active is low.
- R11: When tc_last is high, eop_out pulses for one clock. The pulse comes in S4 in normal timing and in S2 in compressed timing. No pulse occurs otherwise.
- R12: eop_in_n low in any working state, even for one clock, is remembered. The service ends at S4 of that transfer, and the block itself does not pulse eop_out.
- R13: addr_en stays high from S1 until S4 of the last transfer. xfer_step is high once per transfer, in S4, with lo_addr_out equal to the low byte of cur_addr. Every service ends with hold_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_req | input | 1 | Arbiter has a channel to serve |
| hold_ack | input | 1 | Bus granted |
| ready | input | 1 | Slow device ready; low inserts waits |
| dreq_active | input | 1 | Selected channel still requesting (demand mode) |
| eop_in_n | input | 1 | External end of process, active low |
| tc_last | input | 1 | Current transfer is the channel's last |
| svc_mode | input | 2 | 00 demand, 01 single, 1x block |
| xfer_type | input | 2 | 01 write, 10 read, 00/11 verify |
| compressed | input | 1 | Two-clock transfer timing |
| addr_down | input | 1 | Address decrements per transfer |
| cur_addr | input | ADDR_W | Current address from register file |
| hold_req | output | 1 | Bus request |
| addr_en | output | 1 | Address enable during the service |
| addr_strobe | output | 1 | Upper-address latch strobe (S1) |
| hi_addr_out | output | ADDR_W-LO_W | Upper address byte, valid in S1 |
| lo_addr_out | output | LO_W | Lower address byte during working states |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| eop_out | output | 1 | Terminal-count end-of-process pulse |
| xfer_step | output | 1 | Transfer completes; register file steps address and count |

## Verification
The bench aims at the address boundaries. It runs an incrementing service across a low-byte carry and a decrementing one across a borrow. A sequencer that compared the wrong bits, or ignored the direction, would emit the wrong number of upper-address strobes or latch a stale upper byte. A one-clock external end-of-process pulse tests that the request is held until S4; a design that only looked at S4 would keep transferring. Wait tests run in both timings and in verify. Sampling ready in the wrong state, or honouring it in verify, shows up as a wrong service length. Compressed timing with a zero count checks that the end pulse lands in S2 rather than S4.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_WAIT = 3'd5,
    ST_S4   = 3'd6
  } seq_state_t;

  localparam logic [1:0] SVC_DEMAND = 2'b00;
  localparam logic [1:0] SVC_SINGLE = 2'b01;

  localparam logic [1:0] XF_WRITE = 2'b01;
  localparam logic [1:0] XF_READ  = 2'b10;

  // A transfer type that really moves data (anything else verifies).
  function automatic logic xfer_moves(input logic [1:0] xt);
    return (xt == XF_WRITE) || (xt == XF_READ);
  endfunction

  // True in every state that owns the bus (S1 through S4 and waits).
  function automatic logic in_working(input seq_state_t s);
    return (s == ST_S1) || (s == ST_S2) || (s == ST_S3) ||
           (s == ST_WAIT) || (s == ST_S4);
  endfunction

endpackage

// File: rtl/dma_seq_addr.sv
`timescale 1ns/1ps
module dma_seq_addr #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              addr_down,
  input  logic              show_hi,
  input  logic              show_lo,
  output logic [HI_W-1:0]   hi_addr_out,
  output logic [LO_W-1:0]   lo_addr_out,
  output logic              hi_moves
);

  // Address the register file will present after this transfer.
  function automatic logic [ADDR_W-1:0] stepped(input logic [ADDR_W-1:0] a,
                                                input logic down);
    return down ? (a - ADDR_W'(1)) : (a + ADDR_W'(1));
  endfunction

  // Upper part of two addresses differs: the external latch is stale.
  function automatic logic upper_differs(input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:LO_W] != b[ADDR_W-1:LO_W];
  endfunction

  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    next_addr   = stepped(cur_addr, addr_down);
    hi_moves    = upper_differs(cur_addr, next_addr);
    hi_addr_out = show_hi ? cur_addr[ADDR_W-1:LO_W] : '0;
    lo_addr_out = show_lo ? cur_addr[LO_W-1:0] : '0;
  end

endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       svc_req,
  input  logic       hold_ack,
  input  logic       ready,
  input  logic       dreq_active,
  input  logic       eop_in_n,
  input  logic       tc_last,
  input  logic [1:0] svc_mode,
  input  logic [1:0] xfer_type,
  input  logic       compressed,
  input  logic       hi_moves,
  output seq_state_t state_q,
  output logic       xfer_step,
  output logic       svc_end
);

  seq_state_t state_d;
  logic       ext_eop_q;
  logic       stall;
  logic       eop_seen;
  logic       finish;

  always_comb begin
    stall    = !ready && xfer_moves(xfer_type);
    eop_seen = !eop_in_n || ext_eop_q;
    finish   = tc_last || eop_seen || (svc_mode == SVC_SINGLE) ||
               ((svc_mode == SVC_DEMAND) && !dreq_active);
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (svc_req) state_d = ST_HOLD;
      ST_HOLD: if (hold_ack) state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2: begin
        if (!compressed)  state_d = ST_S3;
        else if (stall)   state_d = ST_WAIT;
        else              state_d = ST_S4;
      end
      ST_S3:   state_d = stall ? ST_WAIT : ST_S4;
      ST_WAIT: if (!stall) state_d = ST_S4;
      ST_S4: begin
        if (finish)        state_d = ST_IDLE;
        else if (hi_moves) state_d = ST_S1;
        else               state_d = ST_S2;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ext_eop_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!in_working(state_q))
        ext_eop_q <= 1'b0;
      else if (!eop_in_n)
        ext_eop_q <= 1'b1;
    end
  end

  assign xfer_step = (state_q == ST_S4);
  assign svc_end   = xfer_step && finish;

endmodule

// File: rtl/dma_seq_strobe.sv
`timescale 1ns/1ps
module dma_seq_strobe
  import dma_seq_pkg::*;
(
  input  seq_state_t state_q,
  input  logic [1:0] xfer_type,
  input  logic       compressed,
  input  logic       tc_last,
  output logic       hold_req,
  output logic       addr_en,
  output logic       addr_strobe,
  output logic       show_hi,
  output logic       show_lo,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       eop_out
);

  logic read_phase;
  logic write_phase;
  logic is_rd;
  logic is_wr;
  logic eop_state;

  always_comb begin
    read_phase  = (state_q == ST_S3) || (state_q == ST_WAIT) || (state_q == ST_S4);
    write_phase = (state_q == ST_WAIT) || (state_q == ST_S4);
    is_rd       = (xfer_type == XF_READ);
    is_wr       = (xfer_type == XF_WRITE);
    eop_state   = compressed ? (state_q == ST_S2) : (state_q == ST_S4);

    hold_req    = (state_q != ST_IDLE);
    addr_en     = in_working(state_q);
    addr_strobe = (state_q == ST_S1);
    show_hi     = addr_strobe;
    show_lo     = addr_en;
    mem_rd      = is_rd && read_phase;
    io_wr       = is_rd && write_phase;
    io_rd       = is_wr && read_phase;
    mem_wr      = is_wr && write_phase;
    eop_out     = tc_last && eop_state;
  end

endmodule

// File: rtl/dma_cycle_seq.sv
`timescale 1ns/1ps
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_req,
  input  logic              hold_ack,
  input  logic              ready,
  input  logic              dreq_active,
  input  logic              eop_in_n,
  input  logic              tc_last,
  input  logic [1:0]        svc_mode,
  input  logic [1:0]        xfer_type,
  input  logic              compressed,
  input  logic              addr_down,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              hold_req,
  output logic              addr_en,
  output logic              addr_strobe,
  output logic [HI_W-1:0]   hi_addr_out,
  output logic [LO_W-1:0]   lo_addr_out,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              eop_out,
  output logic              xfer_step
);

  seq_state_t state_q;
  logic       hi_moves;
  logic       svc_end;
  logic       show_hi;
  logic       show_lo;

  dma_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .svc_req     (svc_req),
    .hold_ack    (hold_ack),
    .ready       (ready),
    .dreq_active (dreq_active),
    .eop_in_n    (eop_in_n),
    .tc_last     (tc_last),
    .svc_mode    (svc_mode),
    .xfer_type   (xfer_type),
    .compressed  (compressed),
    .hi_moves    (hi_moves),
    .state_q     (state_q),
    .xfer_step   (xfer_step),
    .svc_end     (svc_end)
  );

  dma_seq_addr #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
    .cur_addr    (cur_addr),
    .addr_down   (addr_down),
    .show_hi     (show_hi),
    .show_lo     (show_lo),
    .hi_addr_out (hi_addr_out),
    .lo_addr_out (lo_addr_out),
    .hi_moves    (hi_moves)
  );

  dma_seq_strobe u_strobe (
    .state_q     (state_q),
    .xfer_type   (xfer_type),
    .compressed  (compressed),
    .tc_last     (tc_last),
    .hold_req    (hold_req),
    .addr_en     (addr_en),
    .addr_strobe (addr_strobe),
    .show_hi     (show_hi),
    .show_lo     (show_lo),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .eop_out     (eop_out)
  );

endmodule

// File: rtl/dma_cycle_seq_chk.sv
`timescale 1ns/1ps
module dma_cycle_seq_chk
  import dma_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input seq_state_t state_q,
  input logic       hold_ack,
  input logic       ready,
  input logic       compressed,
  input logic [1:0] xfer_type,
  input logic [1:0] svc_mode,
  input logic       dreq_active,
  input logic       hold_req,
  input logic       addr_en,
  input logic       addr_strobe,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       io_rd,
  input logic       io_wr,
  input logic       eop_out,
  input logic       xfer_step,
  input logic       svc_end
);

  // R2
  first_state_s1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_en) |-> addr_strobe);

  // R2
  hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !hold_ack) |=> !addr_en);

  // R4
  compressed_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_S2 && compressed) |=> (state_q != ST_S3));

  // R5
  wait_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !ready) |=> (state_q == ST_WAIT));

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr || mem_wr) |-> (mem_rd || io_rd));

  // R6
  one_read_side_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, io_rd}));

  // R7
  verify_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_type != XF_READ && xfer_type != XF_WRITE) |->
      !(mem_rd || mem_wr || io_rd || io_wr));

  // R8
  single_release_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_step && svc_mode == SVC_SINGLE) |=> !addr_en);

  // R10
  demand_release_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_step && svc_mode == SVC_DEMAND && !dreq_active) |=> !hold_req);

  // R11
  eop_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    eop_out |=> !eop_out);

  // R13
  enable_held_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_en && !svc_end) |=> addr_en);

  // R13
  end_drops_hold_chk: assert property (@(posedge clk) disable iff (rst)
    svc_end |=> !addr_en);

endmodule

bind dma_cycle_seq dma_cycle_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .state_q     (state_q),
  .hold_ack    (hold_ack),
  .ready       (ready),
  .compressed  (compressed),
  .xfer_type   (xfer_type),
  .svc_mode    (svc_mode),
  .dreq_active (dreq_active),
  .hold_req    (hold_req),
  .addr_en     (addr_en),
  .addr_strobe (addr_strobe),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .eop_out     (eop_out),
  .xfer_step   (xfer_step),
  .svc_end     (svc_end)
);

// File: tb/dma_cycle_seq_test.sv
`timescale 1ns/1ps
module dma_cycle_seq_test;

  localparam logic [1:0] M_DEMAND = 2'b00;
  localparam logic [1:0] M_SINGLE = 2'b01;
  localparam logic [1:0] M_BLOCK  = 2'b10;
  localparam logic [1:0] T_VERIFY = 2'b00;
  localparam logic [1:0] T_WRITE  = 2'b01;
  localparam logic [1:0] T_READ   = 2'b10;

  logic        clk = 1'b0;
  logic        rst;
  logic        svc_req, hold_ack, ready, dreq_active, eop_in_n, tc_last;
  logic [1:0]  svc_mode, xfer_type;
  logic        compressed, addr_down;
  logic [15:0] cur_addr;
  logic        hold_req, addr_en, addr_strobe;
  logic [7:0]  hi_addr_out, lo_addr_out;
  logic        mem_rd, mem_wr, io_rd, io_wr, eop_out, xfer_step;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_cycle_seq uut (
    .clk(clk), .rst(rst), .svc_req(svc_req), .hold_ack(hold_ack), .ready(ready),
    .dreq_active(dreq_active), .eop_in_n(eop_in_n), .tc_last(tc_last),
    .svc_mode(svc_mode), .xfer_type(xfer_type), .compressed(compressed),
    .addr_down(addr_down), .cur_addr(cur_addr), .hold_req(hold_req),
    .addr_en(addr_en), .addr_strobe(addr_strobe), .hi_addr_out(hi_addr_out),
    .lo_addr_out(lo_addr_out), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .eop_out(eop_out), .xfer_step(xfer_step)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; svc_req = 0; hold_ack = 0; ready = 1; dreq_active = 1;
    eop_in_n = 1; tc_last = 0; svc_mode = M_BLOCK; xfer_type = T_READ;
    compressed = 0; addr_down = 0; cur_addr = 16'h0000;
    repeat (3) @(posedge clk);
    #2;
    check_eq("R1", "outputs in reset",
             int'({hold_req, addr_en, addr_strobe, mem_rd, mem_wr, io_rd, io_wr, eop_out, xfer_step}), 0);
    rst = 1'b0;
    @(posedge clk); #2;
    check_eq("R1", "outputs after reset",
             int'({hold_req, addr_en, addr_strobe, mem_rd, mem_wr, io_rd, io_wr, eop_out, xfer_step}), 0);
  endtask

  // One service, from request to release, checked against a model of the requirements.
  task automatic run_service(input string rq_end, input logic [1:0] mode, input logic [1:0] xf,
                             input bit comp, input bit down, input logic [15:0] start,
                             input int count, input int dlen, input int eop_at, input int wait_len);
    int exp_n, exp_cyc, exp_s1, exp_tc, waits, rd_per, exp_rd, exp_wr;
    int seen, wcnt, s1_cnt, hi_err, lo_err, eop_cnt, eop_pos_err, guard, cnt;
    int c_mrd, c_mwr, c_ird, c_iwr;
    bit pend, moving, eop_done;
    logic [15:0] addr, a, prev;

    moving = (xf == T_READ) || (xf == T_WRITE);
    if (mode == M_SINGLE)      exp_n = 1;
    else if (mode == M_DEMAND) exp_n = (dlen < count + 1) ? dlen : count + 1;
    else                       exp_n = count + 1;
    if (eop_at >= 0 && eop_at + 1 < exp_n) exp_n = eop_at + 1;
    exp_tc = (exp_n == count + 1) ? 1 : 0;
    exp_cyc = 0; exp_s1 = 0; prev = start;
    for (int i = 0; i < exp_n; i++) begin
      a = down ? (start - 16'(i)) : (start + 16'(i));
      if (i == 0 || a[15:8] != prev[15:8]) begin exp_s1++; exp_cyc++; end
      exp_cyc += comp ? 2 : 3;
      prev = a;
    end
    waits = (wait_len > 0 && moving) ? (comp ? wait_len - 1 : wait_len - 2) : 0;
    exp_cyc += waits;
    rd_per = comp ? 1 : 2;
    exp_rd = moving ? exp_n * rd_per + waits : 0;
    exp_wr = moving ? exp_n + waits : 0;

    svc_mode = mode; xfer_type = xf; compressed = comp; addr_down = down;
    addr = start; cnt = count; cur_addr = addr; tc_last = (cnt == 0);
    ready = 1; dreq_active = 1; eop_in_n = 1; hold_ack = 0;
    svc_req = 1;
    @(posedge clk); #2;
    check_eq("R2", "hold_req after request", int'(hold_req), 1);
    check_eq("R2", "addr_en before grant", int'(addr_en), 0);
    svc_req = 0;
    repeat (2) @(posedge clk);
    #2;
    check_eq("R2", "addr_en while grant withheld", int'(addr_en), 0);
    hold_ack = 1;

    seen = 0; wcnt = 0; s1_cnt = 0; hi_err = 0; lo_err = 0; eop_cnt = 0;
    eop_pos_err = 0; guard = 0; pend = 0; eop_done = 0;
    c_mrd = 0; c_mwr = 0; c_ird = 0; c_iwr = 0;
    forever begin
      @(posedge clk); #1;
      if (pend) begin
        addr = down ? addr - 16'd1 : addr + 16'd1;
        cnt--; pend = 0;
      end
      cur_addr = addr; tc_last = (cnt == 0);
      dreq_active = (mode == M_DEMAND) ? (seen + 1 < dlen) : 1'b1;
      if (eop_at >= 0 && seen == eop_at && !eop_done) begin
        eop_in_n = 0; eop_done = 1;
      end else eop_in_n = 1;
      ready = !(wait_len > 0 && wcnt + 1 <= wait_len);
      #1;
      if (!addr_en) break;
      wcnt++;
      if (wcnt == 1) check_eq("R2", "first working state strobes upper byte", int'(addr_strobe), 1);
      if (addr_strobe) begin
        s1_cnt++;
        if (hi_addr_out != addr[15:8]) hi_err++;
      end
      c_mrd += int'(mem_rd); c_mwr += int'(mem_wr); c_ird += int'(io_rd); c_iwr += int'(io_wr);
      if (eop_out) begin
        eop_cnt++;
        if (comp ? xfer_step : !xfer_step) eop_pos_err++;
      end
      if (xfer_step) begin
        seen++; pend = 1;
        if (lo_addr_out != addr[7:0]) lo_err++;
      end
      guard++;
      if (guard > 5000) begin
        check_eq(rq_end, "service never ended", guard, 0);
        break;
      end
    end
    hold_ack = 0; eop_in_n = 1; ready = 1; dreq_active = 1;
    check_eq(rq_end, "transfers made", seen, exp_n);
    check_eq("R13", "hold_req after service", int'(hold_req), 0);
    check_eq(wait_len > 0 ? "R5" : "R4", "working clocks", wcnt, exp_cyc);
    check_eq("R3", "upper byte strobes", s1_cnt, exp_s1);
    check_eq("R3", "wrong upper byte", hi_err, 0);
    check_eq("R13", "wrong low byte at step", lo_err, 0);
    check_eq(moving ? "R6" : "R7", "mem_rd clocks", c_mrd, (xf == T_READ) ? exp_rd : 0);
    check_eq(moving ? "R6" : "R7", "io_wr clocks", c_iwr, (xf == T_READ) ? exp_wr : 0);
    check_eq(moving ? "R6" : "R7", "io_rd clocks", c_ird, (xf == T_WRITE) ? exp_rd : 0);
    check_eq(moving ? "R6" : "R7", "mem_wr clocks", c_mwr, (xf == T_WRITE) ? exp_wr : 0);
    check_eq("R11", "eop pulses", eop_cnt, exp_tc);
    check_eq("R11", "eop in wrong state", eop_pos_err, 0);
    @(posedge clk); #2;
    check_eq("R13", "idle after service", int'({hold_req, addr_en}), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    // R9 R3: incrementing block read across a carry, normal timing
    run_service("R9", M_BLOCK, T_READ, 0, 0, 16'h12FE, 3, 0, -1, 0);
    // R9 R3: decrementing block write across a borrow, compressed timing
    run_service("R9", M_BLOCK, T_WRITE, 1, 1, 16'h4001, 4, 0, -1, 0);
    // R10 R7: demand verify, request drops after three transfers
    run_service("R10", M_DEMAND, T_VERIFY, 0, 0, 16'h00FF, 10, 3, -1, 0);
    // R8: single read, count not exhausted
    run_service("R8", M_SINGLE, T_READ, 0, 0, 16'h2000, 5, 0, -1, 0);
    // R8 R11: single compressed read on the last count
    run_service("R8", M_SINGLE, T_READ, 1, 0, 16'h3456, 0, 0, -1, 0);
    // R12: one-clock external end in transfer two of a block
    run_service("R12", M_BLOCK, T_READ, 0, 0, 16'h0010, 9, 0, 1, 0);
    // R5: waits in normal and compressed timing
    run_service("R8", M_SINGLE, T_READ, 0, 0, 16'h0500, 5, 0, -1, 5);
    run_service("R8", M_SINGLE, T_WRITE, 1, 1, 16'h0600, 5, 0, -1, 4);
    // R7: ready ignored in verify
    run_service("R8", M_SINGLE, T_VERIFY, 0, 0, 16'h0700, 5, 0, -1, 5);
    // R9 R11: block write to terminal count, normal timing
    run_service("R9", M_BLOCK, T_WRITE, 0, 1, 16'h8000, 2, 0, -1, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule